// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache with write-back behaviour. It sits between a 32-bit load/store port on the processor side and a memory port that only moves whole lines. With the default parameters it holds 16 KB in 512 lines of 32 bytes. Loads and stores can be one, two or four bytes wide. The processor can also send two line commands:

- **write-back** copies a line to memory if it is present and dirty;
- **prefetch** brings a line in if it is absent.

A modified line stays in the cache until a conflicting miss evicts it or a write-back command cleans it. Nothing cleans lines in the background. Any miss, including a one-byte store, fetches the whole line first. The new bytes are then merged into the cached copy.

The processor port uses valid/ready handshaking. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the moment a request that needs memory is taken until its response is presented. The response is a single-cycle `rsp_valid` pulse with no back-pressure, so the requester must always be able to take it.

On the memory side, `mem_req` is held high, together with a stable address, direction and write data, until the single-cycle `mem_ack` arrives. For a read, `mem_rdata` is sampled on the edge that sees `mem_ack`. The memory port uses plain request/acknowledge and does not follow the valid/ready rules.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and both `rsp_valid` and `mem_req` are 0. The first access to any address fetches its line from memory.
- R2: A load (`req_op`=0) returns the addressed bytes in `rsp_rdata`, extended to 32 bits.
  - Size encoding (`req_size`): 0 = byte, 1 = halfword, 2 = word.
  - Byte order is little-endian: line byte k is at address offset k and lands in bits 8k+7:8k of the line bus.
  - `req_signed`=1 sign-extends the result; `req_signed`=0 zero-extends it.
  - On a hit the response is presented one cycle after the accepting edge.
- R3: A store (`req_op`=1) changes only the bytes selected by its size and address. All other bytes of the line keep their values.
- R4: Every memory transfer moves one whole line, and its address has the line-offset bits at zero.
- R5: A store that misses first reads the line from memory and then merges the store data into it. Memory keeps its old copy of the line until that line is written back.
- R6: A miss whose victim line is valid and dirty first writes the victim to memory, then reads the requested line.
- R7: A write-back command (`req_op`=2) that hits a dirty line writes that line to memory and marks it clean. The line stays valid, so a later load to it hits.
- R8: A write-back command that hits a clean line, or names an absent line, makes no memory transfer and responds one cycle after acceptance.
- R9: A prefetch command (`req_op`=3) reads a missing line into the cache. On a line that is already present it makes no memory transfer and responds one cycle after acceptance.
- R10: These loads and stores are misaligned:
  - a halfword with address bit 0 set;
  - a word whose address bits 1:0 are not zero;
  - any access with size 3.
  A misaligned load or store responds one cycle after acceptance with `rsp_err`=1. It changes no data and makes no memory transfer.
- R11: Handshake rules:
  - `req_ready` is low while a line transfer is in progress.
  - Each accepted request gets exactly one `rsp_valid` pulse.
  - `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 write-back line, 3 prefetch line |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Extended load data (0 for other operations) |
| rsp_err | output | 1 | Misaligned access rejected |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line being written |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | LINE_BYTES*8 | Line returned on a read |

## Verification
Hits, misaligned requests, write-back no-ops and prefetch hits present `rsp_valid` one cycle after the accepting edge. A miss presents it two edges after the edge that samples the fill acknowledge. A dirty write-back presents it one edge after its write acknowledge. The bench drives and samples on falling edges and counts falling edges from acceptance up to the response. It checks a latency of exactly 1 wherever a request must not touch memory. It compares read and write transfer counts, and the order of the last two transfers, taken before and after each directed request. A bench memory model acknowledges after a random 1 to 4 cycles, so a check that relies on fixed miss timing would fail.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CLEAN = 2'd2,
    OP_FETCH = 2'd3
  } dc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_DONE,
    ST_CLEAN
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 512,
  parameter int TAG_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] idx,
  output logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_valid,
  output logic                     rd_dirty,
  input  logic                     fill_en,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic                     dirty_set,
  input  logic                     dirty_clr
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  // valid and dirty flags are the only reset state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_set) dirty_q[idx] <= 1'b1;
      if (dirty_clr) dirty_q[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end
endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32
) (
  input  logic                       clk,
  input  logic [$clog2(LINES)-1:0]   idx,
  output logic [LINE_BYTES*8-1:0]    rd_line,
  input  logic                       fill_en,
  input  logic [LINE_BYTES*8-1:0]    fill_line,
  input  logic [LINE_BYTES-1:0]      be,
  input  logic [LINE_BYTES*8-1:0]    wr_line
);
  localparam int LINE_W = LINE_BYTES * 8;

  logic [LINE_W-1:0] data_q [LINES];

  assign rd_line = data_q[idx];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[idx] <= fill_line;
    end else begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (be[b]) data_q[idx][8*b +: 8] <= wr_line[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/dc_lane.sv
module dc_lane #(
  parameter int LINE_BYTES = 32
) (
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [1:0]                    size,
  input  logic                          sign,
  input  logic [31:0]                   wdata,
  input  logic [LINE_BYTES*8-1:0]       line,
  output logic [LINE_BYTES-1:0]         be,
  output logic [LINE_BYTES*8-1:0]       wline,
  output logic [31:0]                   rdata,
  output logic                          misaligned
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [OFF_W:0] nbytes, lo, hi;
  logic [31:0]    word;
  logic [7:0]     byte_v;
  logic [15:0]    half_v;

  always_comb begin
    unique case (size)
      2'd0:    nbytes = (OFF_W+1)'(1);
      2'd1:    nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(4);
    endcase
    misaligned = (size == 2'd3) ||
                 (size == 2'd1 && off[0]) ||
                 (size == 2'd2 && off[1:0] != 2'd0);
    lo = {1'b0, off};
    hi = lo + nbytes;
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    localparam logic [OFF_W:0] BPOS = (OFF_W+1)'(b);
    localparam logic [1:0]     BLANE = 2'(b);
    logic [1:0] src;
    assign src = BLANE - off[1:0];
    assign be[b] = !misaligned && (BPOS >= lo) && (BPOS < hi);
    assign wline[8*b +: 8] = wdata[8*src +: 8];
  end

  always_comb begin
    word   = line[32*off[OFF_W-1:2] +: 32];
    byte_v = word[8*off[1:0] +: 8];
    half_v = word[16*off[1] +: 16];
    unique case (size)
      2'd0:    rdata = {{24{sign & byte_v[7]}}, byte_v};
      2'd1:    rdata = {{16{sign & half_v[15]}}, half_v};
      default: rdata = word;
    endcase
  end
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [1:0]              req_size,
  input  logic                    req_signed,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_err,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;

  dc_state_e state_q, state_d;
  dc_op_e    q_op, cur_op;
  logic [1:0]        q_size, cur_size;
  logic              q_sign, cur_sign;
  logic [ADDR_W-1:0] q_addr, cur_addr;
  logic [31:0]       q_wdata, cur_wdata;

  logic idle, acc, hit, is_access, latch, do_acc, do_store, fin, fin_err;
  logic fill_en, dirty_clr;
  logic [IDX_W-1:0]      cur_idx;
  logic [TAG_W-1:0]      cur_tag, rd_tag;
  logic                  rd_valid, rd_dirty, misaligned;
  logic [LINE_W-1:0]     rd_line, wline;
  logic [LINE_BYTES-1:0] be;
  logic [31:0]           lane_rdata;

  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle;
  assign acc       = req_valid && idle;

  // lookup uses the live request while idle, the held request otherwise
  assign cur_op    = idle ? dc_op_e'(req_op) : q_op;
  assign cur_size  = idle ? req_size   : q_size;
  assign cur_sign  = idle ? req_signed : q_sign;
  assign cur_addr  = idle ? req_addr   : q_addr;
  assign cur_wdata = idle ? req_wdata  : q_wdata;
  assign cur_idx   = cur_addr[OFF_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];

  assign hit       = rd_valid && (rd_tag == cur_tag);
  assign is_access = (cur_op == OP_LOAD) || (cur_op == OP_STORE);
  assign do_store  = do_acc && (cur_op == OP_STORE);

  dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk, .rst_n, .idx(cur_idx), .rd_tag, .rd_valid, .rd_dirty,
    .fill_en, .fill_tag(cur_tag), .dirty_set(do_store), .dirty_clr
  );

  dc_line_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_lines (
    .clk, .idx(cur_idx), .rd_line, .fill_en, .fill_line(mem_rdata),
    .be(do_store ? be : '0), .wr_line(wline)
  );

  dc_lane #(.LINE_BYTES(LINE_BYTES)) i_lane (
    .off(cur_addr[OFF_W-1:0]), .size(cur_size), .sign(cur_sign),
    .wdata(cur_wdata), .line(rd_line), .be, .wline,
    .rdata(lane_rdata), .misaligned
  );

  always_comb begin
    state_d   = state_q;
    latch     = 1'b0;
    do_acc    = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    fill_en   = 1'b0;
    dirty_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (acc) begin
        if (is_access && misaligned) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else if (cur_op == OP_CLEAN) begin
          if (hit && rd_dirty) begin
            latch   = 1'b1;
            state_d = ST_CLEAN;
          end else begin
            fin = 1'b1;
          end
        end else if (hit) begin
          do_acc = is_access;
          fin    = 1'b1;
        end else begin
          latch   = 1'b1;
          state_d = (rd_valid && rd_dirty) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: if (mem_ack) state_d = ST_FILL;
      ST_FILL: if (mem_ack) begin
        fill_en = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: begin
        do_acc  = is_access;
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      ST_CLEAN: if (mem_ack) begin
        dirty_clr = 1'b1;
        fin       = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      q_op      <= OP_LOAD;
      q_size    <= '0;
      q_sign    <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= fin;
      if (latch) begin
        q_op    <= cur_op;
        q_size  <= cur_size;
        q_sign  <= cur_sign;
        q_addr  <= cur_addr;
        q_wdata <= cur_wdata;
      end
      if (fin) begin
        rsp_err   <= fin_err;
        rsp_rdata <= (do_acc && cur_op == OP_LOAD) ? lane_rdata : 32'd0;
      end
    end
  end

  // eviction and clean write the resident tag, a fill reads the requested tag
  assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_CLEAN);
  assign mem_we    = (state_q == ST_EVICT) || (state_q == ST_CLEAN);
  assign mem_addr  = {(state_q == ST_FILL) ? cur_tag : rd_tag, cur_idx, {OFF_W{1'b0}}};
  assign mem_wdata = rd_line;
endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  logic taken, bad_align;
  assign taken     = req_valid && req_ready;
  assign bad_align = (req_op[1] == 1'b0) &&
                     ((req_size == 2'd3) ||
                      (req_size == 2'd1 && req_addr[0]) ||
                      (req_size == 2'd2 && req_addr[1:0] != 2'd0));

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_ACCEPT_FOLLOWUP: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (rsp_valid || !req_ready)); // R11
  AST_RSP_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && !mem_req)); // R11
  AST_NO_MEM_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R11
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && bad_align) |=> (rsp_valid && rsp_err && !mem_req)); // R10
endmodule

bind dcache_wb dcache_wb_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_size(req_size), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/test_dcache_wb.sv
module test_dcache_wb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_signed = 1'b0;
  logic [1:0] req_op = '0, req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_err, mem_req, mem_we, mem_ack;
  logic [31:0] rsp_rdata, mem_addr;
  logic [255:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  dcache_wb i_dcache_wb (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_size, .req_signed,
    .req_addr, .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata
  );

  logic [255:0] bmem [2048];
  logic [255:0] gold [2048];
  int n_run = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  logic [7:0]  hist = '0;
  logic [31:0] last_wr = '0;
  bit stall_bad = 0;

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges after 1..4 falling edges
  initial begin
    int wait_cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          if (mem_addr[4:0] != 5'd0) chk("R4", "line alignment", {251'd0, mem_addr[4:0]}, '0);
          if (mem_we) begin
            bmem[mem_addr[15:5]] = mem_wdata;
            n_wr++;
            last_wr = mem_addr;
          end else begin
            mem_rdata = bmem[mem_addr[15:5]];
            n_rd++;
          end
          hist = {hist[6:0], mem_we};
          mem_ack = 1'b1;
          wait_cnt = $urandom_range(0, 3);
        end
      end
    end
  end

  task automatic access(input logic [1:0] op, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin
      if (req_ready) stall_bad = 1;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  function automatic bit misal(logic [1:0] sz, logic [31:0] a);
    return (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
  endfunction

  function automatic logic [31:0] exp_load(logic [1:0] sz, logic sg, logic [31:0] a);
    logic [255:0] ln = gold[a[15:5]];
    logic [7:0]  b = ln[8*a[4:0] +: 8];
    logic [15:0] h = ln[8*a[4:0] +: 16];
    case (sz)
      2'd0:    return {{24{sg & b[7]}}, b};
      2'd1:    return {{16{sg & h[15]}}, h};
      default: return ln[8*a[4:0] +: 32];
    endcase
  endfunction

  task automatic gold_store(logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) gold[a[15:5]][8*(a[4:0]+k) +: 8] = wd[8*k +: 8];
  endtask

  function automatic logic [31:0] la(int t, int i);
    return {16'd0, 2'(t), 9'(i), 5'd0};
  endfunction

  function automatic logic [31:0] pick_addr(logic [1:0] sz);
    int sel = $urandom_range(0, 3);
    int idx = (sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 5 : 511;
    logic [4:0] off = 5'($urandom_range(0, 31));
    if ($urandom_range(0, 11) != 0) begin
      if (sz == 2'd1) off[0] = 1'b0;
      if (sz == 2'd2) off[1:0] = 2'b00;
    end
    return la($urandom_range(0, 3), idx) | {27'd0, off};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R11 watchdog: actual hung expected response");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, a;
    logic er;
    int lat, r0, w0;
    logic [255:0] saved;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) begin
      for (int w = 0; w < 8; w++) bmem[i][32*w +: 32] = $urandom;
      gold[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", {255'd0, req_ready}, 256'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", {255'd0, req_ready}, 256'd1);
    chk("R1", "rsp_valid after reset", {255'd0, rsp_valid}, 256'd0);
    chk("R1", "mem_req after reset", {255'd0, mem_req}, 256'd0);

    // cold miss then hit
    r0 = n_rd; w0 = n_wr;
    access(2'd0, 2'd2, 1'b0, la(0, 1) + 4, 0, rd, er, lat);
    chk("R2", "word load miss data", rd, exp_load(2'd2, 1'b0, la(0, 1) + 4));
    chk("R1", "cold miss reads one line", n_rd - r0, 1);
    chk("R1", "cold miss writes nothing", n_wr - w0, 0);
    r0 = n_rd;
    access(2'd0, 2'd2, 1'b0, la(0, 1) + 4, 0, rd, er, lat);
    chk("R2", "hit latency", lat, 1);
    chk("R2", "hit no memory", n_rd - r0, 0);

    // byte store on hit and extension
    access(2'd1, 2'd0, 1'b0, la(0, 1) + 6, 32'h0000AB85, rd, er, lat);
    gold_store(2'd0, la(0, 1) + 6, 32'h0000AB85);
    chk("R3", "store hit latency", lat, 1);
    access(2'd0, 2'd0, 1'b1, la(0, 1) + 6, 0, rd, er, lat);
    chk("R2", "signed byte", rd, 32'hFFFFFF85);
    access(2'd0, 2'd0, 1'b0, la(0, 1) + 6, 0, rd, er, lat);
    chk("R2", "unsigned byte", rd, 32'h00000085);
    access(2'd0, 2'd1, 1'b1, la(0, 1) + 6, 0, rd, er, lat);
    chk("R2", "signed half", rd, exp_load(2'd1, 1'b1, la(0, 1) + 6));
    access(2'd0, 2'd2, 1'b0, la(0, 1) + 4, 0, rd, er, lat);
    chk("R3", "byte merged into word", rd, exp_load(2'd2, 1'b0, la(0, 1) + 4));

    // halfword store miss
    saved = bmem[la(0, 5) >> 5];
    r0 = n_rd; w0 = n_wr;
    access(2'd1, 2'd1, 1'b0, la(0, 5) + 10, 32'h1234BEEF, rd, er, lat);
    gold_store(2'd1, la(0, 5) + 10, 32'h1234BEEF);
    chk("R5", "store miss fetches line", n_rd - r0, 1);
    chk("R5", "store miss no write", n_wr - w0, 0);
    chk("R5", "memory keeps old line", bmem[la(0, 5) >> 5], saved);
    access(2'd0, 2'd2, 1'b0, la(0, 5) + 8, 0, rd, er, lat);
    chk("R5", "merged after fill", rd, exp_load(2'd2, 1'b0, la(0, 5) + 8));

    // write-back command
    w0 = n_wr;
    access(2'd2, 2'd0, 1'b0, la(0, 5), 0, rd, er, lat);
    chk("R7", "clean writes once", n_wr - w0, 1);
    chk("R7", "clean data", bmem[la(0, 5) >> 5], gold[la(0, 5) >> 5]);
    w0 = n_wr;
    access(2'd2, 2'd0, 1'b0, la(0, 5), 0, rd, er, lat);
    chk("R8", "second clean latency", lat, 1);
    chk("R8", "second clean no write", n_wr - w0, 0);
    r0 = n_rd;
    access(2'd0, 2'd2, 1'b0, la(0, 5) + 8, 0, rd, er, lat);
    chk("R7", "line stays valid", lat, 1);
    chk("R7", "no refetch", n_rd - r0, 0);
    r0 = n_rd; w0 = n_wr;
    access(2'd2, 2'd0, 1'b0, la(3, 1), 0, rd, er, lat);
    chk("R8", "absent clean latency", lat, 1);
    chk("R8", "absent clean no memory", (n_rd - r0) + (n_wr - w0), 0);

    // prefetch
    r0 = n_rd;
    access(2'd3, 2'd0, 1'b0, la(0, 0), 0, rd, er, lat);
    chk("R9", "prefetch miss reads line", n_rd - r0, 1);
    r0 = n_rd;
    access(2'd0, 2'd2, 1'b0, la(0, 0) + 12, 0, rd, er, lat);
    chk("R9", "load after prefetch hits", lat, 1);
    chk("R9", "load after prefetch data", rd, exp_load(2'd2, 1'b0, la(0, 0) + 12));
    access(2'd3, 2'd0, 1'b0, la(0, 0), 0, rd, er, lat);
    chk("R9", "prefetch hit latency", lat, 1);
    chk("R9", "prefetch hit no memory", n_rd - r0, 0);

    // dirty victim
    access(2'd1, 2'd2, 1'b0, la(1, 511), 32'hCAFE0001, rd, er, lat);
    gold_store(2'd2, la(1, 511), 32'hCAFE0001);
    r0 = n_rd; w0 = n_wr;
    access(2'd0, 2'd2, 1'b0, la(2, 511) + 16, 0, rd, er, lat);
    chk("R6", "victim written", n_wr - w0, 1);
    chk("R6", "new line read", n_rd - r0, 1);
    chk("R6", "write before read", {254'd0, hist[1:0]}, 256'd2);
    chk("R6", "victim address", last_wr, la(1, 511));
    chk("R6", "victim data", bmem[la(1, 511) >> 5], gold[la(1, 511) >> 5]);
    chk("R6", "load data after eviction", rd, exp_load(2'd2, 1'b0, la(2, 511) + 16));

    // misaligned
    r0 = n_rd; w0 = n_wr;
    access(2'd1, 2'd1, 1'b0, la(0, 1) + 9, 32'hFFFF, rd, er, lat);
    chk("R10", "misaligned half store err", {255'd0, er}, 256'd1);
    chk("R10", "misaligned latency", lat, 1);
    access(2'd0, 2'd2, 1'b0, la(0, 1) + 2, 0, rd, er, lat);
    chk("R10", "misaligned word load err", {255'd0, er}, 256'd1);
    chk("R10", "misaligned no memory", (n_rd - r0) + (n_wr - w0), 0);
    access(2'd0, 2'd2, 1'b0, la(0, 1) + 8, 0, rd, er, lat);
    chk("R10", "data unchanged", rd, exp_load(2'd2, 1'b0, la(0, 1) + 8));

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [1:0] sz = 2'($urandom_range(0, 2));
      logic sg = 1'($urandom_range(0, 1));
      logic [31:0] wd = $urandom;
      a = pick_addr(sz);
      access(op, sz, sg, a, wd, rd, er, lat);
      if (op <= 2'd1) begin
        chk("R10", "random err flag", {255'd0, er}, {255'd0, misal(sz, a)});
        if (!misal(sz, a)) begin
          if (op == 2'd0) chk("R2", "random load", rd, exp_load(sz, sg, a));
          else gold_store(sz, a, wd);
        end
      end
    end

    // flush everything and compare memory
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        int idx = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 5 : 511;
        access(2'd2, 2'd0, 1'b0, la(t, idx), 0, rd, er, lat);
      end
    end
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        int idx = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 5 : 511;
        chk("R7", "memory after flush", bmem[la(t, idx) >> 5], gold[la(t, idx) >> 5]);
      end
    end
    chk("R11", "ready low while busy", {255'd0, stall_bad}, 256'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule